// File: doc/BRIEF.md
# Timed Average-Period Measurement Unit

This unit estimates the average frequency of a pulse train without doing any division. It opens a timed window of a programmable number of clock cycles. Inside that window it notes the first selected transition of the input. From then on it counts the clock ticks and the later selected transitions. When the window closes it publishes two numbers: the tick distance from the first to the last selected transition, and the number of whole input periods between them. The host divides the first by the second to get the mean period.

A new window opens automatically the cycle after the previous one closes, so results arrive at a steady rate for as long as the unit stays enabled. A window is opened by the rising edge of the enable level, or restarted by a trigger pulse while enabled. The input is assumed to be already conditioned and free of glitches. It is registered once before edge detection.

Top module: `avg_period_meter`

## Requirements
- R1: While reset is held and after its release, `res_hi_o`, `res_lo_o` and `res_vld_o` are all zero until the first window closes.
- R2: A window starts on the cycle in which `enable_i` is sampled high after having been low, or `trig_i` is sampled high with `enable_i` high. A window lasts `win_len_i` clock edges (`win_len_i` is at least 1). If the start is seen at edge S, the window covers edges S+1 to S+win_len_i, and `res_vld_o` is high in the cycle after edge S+win_len_i.
- R3: `edge_sel_i` = 0 selects rising transitions of `sig_i`, and `edge_sel_i` = 1 selects falling transitions. Transitions of the other polarity have no effect on the results.
- R4: `res_lo_o` gives the number of selected transitions in the closed window minus one, which is the number of whole periods.
- R5: `res_hi_o` gives the number of clock cycles from the first to the last selected transition in the closed window, and it is never below `res_lo_o`.
- R6: A window holding fewer than two selected transitions publishes zero on both result outputs.
- R7: Windows follow one another with no gap while enabled. A transition in a window's final cycle belongs to that window, and the next cycle belongs to the next window.
- R8: `res_vld_o` is a single-cycle strobe raised only when a window closes. The result outputs change only together with that strobe.
- R9: Dropping `enable_i` abandons the open window. No strobe follows, and the previous results stay on the outputs.
- R10: A trigger during an open window discards what that window had gathered, without a strobe, and starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all ticks are counted in it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Level that allows measurement; its rising edge opens a window |
| trig_i | input | 1 | One-cycle pulse that restarts the window while enabled |
| edge_sel_i | input | 1 | 0 selects rising, 1 selects falling transitions |
| sig_i | input | 1 | Conditioned pulse train being measured |
| win_len_i | input | WIN_W | Window length in clock cycles |
| res_hi_o | output | CNT_W | Ticks from first to last selected transition |
| res_lo_o | output | CNT_W | Whole periods seen (transitions minus one) |
| res_vld_o | output | 1 | One-cycle strobe when the results update |

## Verification
The bound assertions check on every cycle that the results move only with the strobe, that the tick span never falls below the period count, and that a zero period count always comes with a zero span. They also check that disabling or triggering is never followed by a strobe. The scenarios alone can show the actual numbers: the span and the count for each polarity, transitions that fall on the final cycle of a window, the zero result for a single transition or for none, and the discarding of gathered data when a trigger arrives mid-window. The bench computes these values from its own transition timetable.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pick_e;
endpackage

// File: rtl/apm_rst_sync.sv
module apm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/apm_edge_det.sv
module apm_edge_det
  import apm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_i,
  input  edge_pick_e pick_i,
  output logic       hit_o
);
  logic cur_q, prev_q;

  // one registered copy of the input plus its delayed copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= sig_i;
      prev_q <= cur_q;
    end
  end

  always_comb begin
    if (pick_i == EDGE_FALL) hit_o = prev_q & ~cur_q;
    else                     hit_o = cur_q & ~prev_q;
  end
endmodule

// File: rtl/apm_window_ctl.sv
module apm_window_ctl #(
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             start_o,
  output logic             run_o,
  output logic             close_o
);
  localparam int WX = WIN_W + 1;

  logic             en_q, en_d;
  logic             open_q, open_d;
  logic [WIN_W-1:0] pos_q, pos_d;
  logic [WX-1:0]    pos_inc;
  logic             pos_ce;

  assign start_o = enable_i & (~en_q | trig_i);
  assign run_o   = open_q & enable_i & ~start_o;
  assign pos_inc = {1'b0, pos_q} + WX'(1);
  assign close_o = run_o & (pos_inc >= {1'b0, win_len_i});

  always_comb begin
    en_d   = enable_i;
    open_d = open_q;
    pos_d  = pos_q;
    pos_ce = 1'b0;
    if (!enable_i) begin
      open_d = 1'b0;
    end else if (start_o) begin
      open_d = 1'b1;
      pos_d  = '0;
      pos_ce = 1'b1;
    end else if (run_o) begin
      pos_ce = 1'b1;
      pos_d  = close_o ? '0 : pos_inc[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      open_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      en_q   <= en_d;
      open_q <= open_d;
      if (pos_ce) pos_q <= pos_d;
    end
  end
endmodule

// File: rtl/apm_accum.sv
module apm_accum #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             close_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] span_o,
  output logic [CNT_W-1:0] periods_o,
  output logic             vld_o
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0] npd_q, npd_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] span_d, periods_d;
  logic             work_ce, pub_ce;

  assign work_ce = run_i | start_i;
  assign pub_ce  = close_i;

  always_comb begin
    armed_d   = armed_q;
    tick_d    = tick_q;
    npd_d     = npd_q;
    hold_d    = hold_q;
    span_d    = span_o;
    periods_d = periods_o;
    if (run_i) begin
      if (armed_q) tick_d = tick_q + CNT_W'(1);
      if (hit_i) begin
        if (!armed_q) begin
          armed_d = 1'b1;
          tick_d  = '0;
          npd_d   = '0;
        end else begin
          npd_d  = npd_q + CNT_W'(1);
          hold_d = tick_q + CNT_W'(1);
        end
      end
    end
    // the closing edge still contributes, then the results are taken
    span_d    = hold_d;
    periods_d = npd_d;
    if (start_i || close_i) begin
      armed_d = 1'b0;
      tick_d  = '0;
      npd_d   = '0;
      hold_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      tick_q    <= '0;
      npd_q     <= '0;
      hold_q    <= '0;
      span_o    <= '0;
      periods_o <= '0;
      vld_o     <= 1'b0;
    end else begin
      vld_o <= pub_ce;
      if (work_ce) begin
        armed_q <= armed_d;
        tick_q  <= tick_d;
        npd_q   <= npd_d;
        hold_q  <= hold_d;
      end
      if (pub_ce) begin
        span_o    <= span_d;
        periods_o <= periods_d;
      end
    end
  end
endmodule

// File: rtl/avg_period_meter.sv
module avg_period_meter
  import apm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             trig_i,
  input  logic             edge_sel_i,
  input  logic             sig_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic [CNT_W-1:0] res_hi_o,
  output logic [CNT_W-1:0] res_lo_o,
  output logic             res_vld_o
);
  logic rst_int_n;
  logic hit, start, run, close_w;

  apm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  apm_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  (sig_i),
    .pick_i (edge_pick_e'(edge_sel_i)),
    .hit_o  (hit)
  );

  apm_window_ctl #(.WIN_W(WIN_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable_i  (enable_i),
    .trig_i    (trig_i),
    .win_len_i (win_len_i),
    .start_o   (start),
    .run_o     (run),
    .close_o   (close_w)
  );

  apm_accum #(.CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .run_i     (run),
    .close_i   (close_w),
    .hit_i     (hit),
    .span_o    (res_hi_o),
    .periods_o (res_lo_o),
    .vld_o     (res_vld_o)
  );
endmodule

// File: rtl/apm_checker.sv
module apm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable_i,
  input logic             trig_i,
  input logic [CNT_W-1:0] res_hi_o,
  input logic [CNT_W-1:0] res_lo_o,
  input logic             res_vld_o
);
  // R8: results move only together with the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> ($stable(res_hi_o) && $stable(res_lo_o)));

  // R5: span in ticks is never smaller than the period count
  p_span_ge_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi_o >= res_lo_o);

  // R6: no whole period means no span
  p_zero_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_lo_o == '0) |-> (res_hi_o == '0));

  // R9: a disabled cycle is never followed by a strobe
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !res_vld_o);

  // R10: a restart is never followed by a strobe
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && trig_i) |=> !res_vld_o);
endmodule

bind avg_period_meter apm_checker #(.CNT_W(CNT_W)) u_apm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .trig_i    (trig_i),
  .res_hi_o  (res_hi_o),
  .res_lo_o  (res_lo_o),
  .res_vld_o (res_vld_o)
);

// File: tb/avg_period_meter_bench.sv
module avg_period_meter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int WIN_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable_i = 1'b0;
  logic             trig_i = 1'b0;
  logic             edge_sel_i = 1'b0;
  logic             sig_i = 1'b0;
  logic [WIN_W-1:0] win_len_i = '0;
  logic [CNT_W-1:0] res_hi_o, res_lo_o;
  logic             res_vld_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avg_period_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_avg_period_meter (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .trig_i(trig_i),
    .edge_sel_i(edge_sel_i), .sig_i(sig_i), .win_len_i(win_len_i),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .res_vld_o(res_vld_o)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // input level at drive slot j for a train of count pulses
  function automatic bit pat(input int j, input int first, input int period,
                             input int width, input int count);
    for (int i = 0; i < count; i++)
      if (j >= first + i*period && j < first + i*period + width) return 1'b1;
    return 1'b0;
  endfunction

  // expected results of window w from the transition timetable
  task automatic expect_win(input int w, input int n, input bit esel, input int first,
                            input int period, input int width, input int count,
                            output longint hi, output longint lo);
    int m = 0, fe = 0, le = 0;
    for (int i = 0; i < count; i++) begin
      int e = first + i*period + (esel ? width : 0);
      if (e >= w*n && e <= (w+1)*n - 1) begin
        if (m == 0) fe = e;
        le = e;
        m++;
      end
    end
    hi = (m >= 2) ? longint'(le - fe) : 0;
    lo = (m >= 2) ? longint'(m - 1) : 0;
  endtask

  // open windows and compare every closing strobe with the timetable
  task automatic run_meas(input string tag, input int n, input bit esel, input bit use_trig,
                          input int first, input int period, input int width,
                          input int count, input int nwin);
    bit stray = 1'b0;
    @(negedge clk); enable_i = 1'b0; trig_i = 1'b0; sig_i = 1'b0;
    @(negedge clk); @(negedge clk);
    edge_sel_i = esel;
    win_len_i = WIN_W'(n);
    if (use_trig) begin
      // a window opened earlier gathers pulses that the trigger must discard
      for (int p = 0; p < 10; p++) begin
        @(negedge clk);
        enable_i = 1'b1;
        sig_i = (p % 4 == 1);
      end
    end
    for (int j = 0; j <= nwin*n + 1; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        bit want = (j >= n + 1) && ((j - 1) % n == 0);
        if (want) begin
          longint eh, el;
          expect_win((j - 1)/n - 1, n, esel, first, period, width, count, eh, el);
          check(res_vld_o == 1'b1, {tag, " R2 strobe at window end"}, res_vld_o, 1);
          check(res_lo_o == CNT_W'(el), {tag, " R4 period count"}, res_lo_o, el);
          check(res_hi_o == CNT_W'(eh), {tag, " R5 tick span"}, res_hi_o, eh);
        end else if (res_vld_o) begin
          stray = 1'b1;
        end
      end
      enable_i = 1'b1;
      trig_i = use_trig && (j == 0);
      sig_i = pat(j, first, period, width, count);
    end
    check(!stray, {tag, " R8 no strobe outside window ends"}, stray, 0);
    @(negedge clk); enable_i = 1'b0; sig_i = 1'b0;
  endtask

  task automatic t_reset;
    check(res_hi_o == '0, "R1 span after reset", res_hi_o, 0);
    check(res_lo_o == '0, "R1 count after reset", res_lo_o, 0);
    check(res_vld_o == 1'b0, "R1 strobe after reset", res_vld_o, 0);
  endtask

  task automatic t_rising;   // R2 R3 R4 R5: span 28, count 4
    run_meas("rising", 40, 1'b0, 1'b0, 3, 7, 3, 5, 1);
  endtask

  task automatic t_falling;  // R3: last fall lands outside, rising would give 5 periods
    run_meas("falling", 34, 1'b1, 1'b0, 2, 6, 2, 6, 1);
  endtask

  task automatic t_sparse;   // R6: one transition, then none
    run_meas("R6 single", 20, 1'b0, 1'b0, 5, 8, 3, 1, 1);
    run_meas("R6 none", 20, 1'b0, 1'b0, 0, 8, 3, 0, 1);
  endtask

  task automatic t_back_to_back; // R7: three windows, a rise on a window's last slot
    run_meas("R7 chain", 16, 1'b0, 1'b0, 1, 5, 2, 10, 3);
  endtask

  task automatic t_trigger;  // R10: pre-trigger pulses must not count
    run_meas("R10 trigger", 24, 1'b0, 1'b1, 2, 4, 2, 4, 1);
  endtask

  task automatic t_disable;  // R9: abandon a window, outputs hold
    logic [CNT_W-1:0] hi0, lo0;
    bit seen = 1'b0;
    run_meas("R9 prep", 12, 1'b0, 1'b0, 1, 3, 1, 4, 1);
    hi0 = res_hi_o; lo0 = res_lo_o;
    @(negedge clk); win_len_i = WIN_W'(20); edge_sel_i = 1'b0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (res_vld_o) seen = 1'b1;
      enable_i = (j < 12);
      sig_i = pat(j, 2, 4, 2, 8);
    end
    check(!seen, "R9 no strobe after disable", seen, 0);
    check(res_hi_o == hi0, "R9 span held", res_hi_o, hi0);
    check(res_lo_o == lo0, "R9 count held", res_lo_o, lo0);
    check(lo0 == CNT_W'(3), "R9 prep count", lo0, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rising();
    t_falling();
    t_sparse();
    t_back_to_back();
    t_trigger();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule